// File: doc/BRIEF.md
# Orbit-Aware Per-Channel Input Delay Tuner

This block lines up the arrival time of several input links to one common target bunch number. A capture stage outside the block records, for each channel, the bunch number at which that channel's marker arrived. The tuner compares that value with a programmable target and moves the channel's input delay so the arrival lands on the target. The delay is 2 bits wide, so it can add 0 to 3 clock ticks. The comparison wraps around the orbit, so an arrival just after the orbit boundary can still be matched to a target just before it.

Bunch numbers run from 1 to `ORBIT_LEN` (3563 by default). Any other captured value means "no valid capture", including the marker 0xDEF, and the channel is left alone. A tuning session lasts while `run_en` is high. When the session opens, the current delays are saved. When it closes, each channel that did not reach its target gets its saved delay back. Within a session, evaluations happen in one of three ways: on every cycle, once every `ORBIT_DIV` orbit ticks, or once per single-step strobe. Before any session starts, software sets the starting delays through a configuration load.

Top module: `dly_tune_top`

## Requirements
- R1: After reset every delay output is 0 and every tuned bit is 0.
- R2: A `cfg_load` pulse loads `cfg_dly` into the delays and clears all tuned bits. This happens only when `run_en` is low in that cycle and was also low in the previous cycle. At any other time the pulse has no effect on either output.
- R3: The required change is target minus arrival, folded into the range -1781..+1781 by adding or subtracting `ORBIT_LEN`. For example, delay 3 with arrival 1 and target 3563 gives delay 2.
- R4: An evaluation with a valid capture and a reachable result (old delay plus change within 0..3) sets the delay to that sum and sets the tuned bit on the next cycle. Examples: delay 0, arrival 6, target 8 gives delay 2. Delay 3, arrival 10, target 8 gives delay 1.
- R5: An evaluation whose result falls outside 0..3 keeps the delay unchanged and clears the tuned bit.
- R6: An evaluation changes neither output of a channel in any of these cases: its valid flag is low, its captured value is 0, 0xDEF or above `ORBIT_LEN`, or the target is outside 1..`ORBIT_LEN`.
- R7: The first cycle with `run_en` high saves every delay as that channel's original value and clears every tuned bit. No evaluation takes place in that cycle.
- R8: The first cycle with `run_en` low after a session restores the original delay on every channel whose tuned bit is clear. Tuned channels keep their delay, and all tuned bits keep their values.
- R9: In continuous mode (`step_mode`=0, `nth_en`=0), every session cycle after the first is an evaluation.
- R10: In orbit mode (`step_mode`=0, `nth_en`=1), an evaluation happens only on every `ORBIT_DIV`-th `orbit_tick`. The count starts from the session start.
- R11: In step mode (`step_mode`=1), an evaluation happens only in session cycles where `step` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Session enable; rising edge starts tuning, falling edge ends it |
| step_mode | input | 1 | Selects single-step evaluation |
| step | input | 1 | Single-step strobe |
| nth_en | input | 1 | Selects evaluation once every ORBIT_DIV orbits |
| orbit_tick | input | 1 | One-cycle pulse per orbit |
| target | input | 12 | Target bunch number |
| cap_bcn | input | NCH*12 | Captured arrival bunch number per channel |
| cap_valid | input | NCH | Captured value is current, per channel |
| cfg_load | input | 1 | Load starting delays (idle only) |
| cfg_dly | input | NCH*2 | Starting delay per channel |
| dly | output | NCH*2 | Applied input delay per channel |
| tuned | output | NCH | Target reached, per channel |

## Verification
The hardest case to reach is the restore path. It needs a channel that first moves its delay in a successful evaluation. A later evaluation in the same session must then find that channel unreachable, and only then can the session close. The restored value differs from the current output only in that order of events. The stimulus gets there with step-mode pulses that repeat the same arrival after the delay has already moved, so the second step overshoots. Wrap-around is covered by directed arrivals on both sides of the orbit boundary. Random targets near bunch numbers 1 and 3563 cover it further.

// File: rtl/dly_tune_pkg.sv
package dly_tune_pkg;
    localparam int BCN_W       = 12;
    localparam int DLY_W       = 2;
    localparam int ORBIT_LEN   = 3563;
    localparam int HALF_ORBIT  = ORBIT_LEN / 2;
    localparam int DLY_MAX     = (1 << DLY_W) - 1;
    localparam logic [BCN_W-1:0] NO_CAPTURE = 12'hDEF;

    typedef logic [BCN_W-1:0] bcn_t;
    typedef logic [DLY_W-1:0] dly_t;

    typedef struct packed {
        logic ok;
        logic reach;
        dly_t next;
    } verdict_t;

    function automatic logic bcn_in_orbit(bcn_t b);
        return (b != '0) && (b != NO_CAPTURE) && (int'(b) <= ORBIT_LEN);
    endfunction

    function automatic int fold_diff(bcn_t tgt, bcn_t arr);
        int d;
        d = int'(tgt) - int'(arr);
        if (d > HALF_ORBIT)
            d = d - ORBIT_LEN;
        else if (d < -HALF_ORBIT)
            d = d + ORBIT_LEN;
        return d;
    endfunction

    function automatic verdict_t judge(bcn_t tgt, bcn_t arr, logic vld, dly_t cur);
        verdict_t v;
        int nd;
        nd      = int'(cur) + fold_diff(tgt, arr);
        v.ok    = vld && bcn_in_orbit(arr) && bcn_in_orbit(tgt);
        v.reach = (nd >= 0) && (nd <= DLY_MAX);
        v.next  = v.reach ? dly_t'(nd) : cur;
        return v;
    endfunction
endpackage

// File: rtl/dly_orbit_pacer.sv
module dly_orbit_pacer #(
    parameter int ORBIT_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic step_mode,
    input  logic step,
    input  logic nth_en,
    input  logic orbit_tick,
    output logic eval,
    output logic start,
    output logic stop,
    output logic idle
);
    localparam int CNT_W = (ORBIT_DIV > 1) ? $clog2(ORBIT_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ORBIT_DIV - 1);

    logic             run_q;
    logic [CNT_W-1:0] orb_cnt;
    logic             orb_mode;
    logic             orb_fire;

    assign orb_mode = nth_en && !step_mode;
    assign orb_fire = orbit_tick && (orb_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            orb_cnt <= '0;
        end else begin
            run_q <= run_en;
            if (!run_en)
                orb_cnt <= '0;
            else if (orbit_tick && orb_mode)
                orb_cnt <= (orb_cnt == LAST) ? '0 : orb_cnt + 1'b1;
        end
    end

    assign start = run_en && !run_q;
    assign stop  = !run_en && run_q;
    assign idle  = !run_en && !run_q;

    always_comb begin
        eval = 1'b0;
        if (run_en && run_q) begin
            if (step_mode)
                eval = step;
            else if (nth_en)
                eval = orb_fire;
            else
                eval = 1'b1;
        end
    end

    AST_STEP_GATES_EVAL: assert property (@(posedge clk) disable iff (rst)
        (step_mode && !step) |-> !eval); // R11
    AST_ORBIT_GATES_EVAL: assert property (@(posedge clk) disable iff (rst)
        (orb_mode && eval) |-> orbit_tick); // R10
    AST_NO_EVAL_AT_START: assert property (@(posedge clk) disable iff (rst)
        start |-> !eval); // R7
endmodule

// File: rtl/dly_chan_tuner.sv
module dly_chan_tuner
    import dly_tune_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic eval,
    input  logic cfg_en,
    input  bcn_t tgt,
    input  bcn_t arr,
    input  logic vld,
    input  dly_t cfg_dly,
    output dly_t dly_o,
    output logic tuned_o
);
    dly_t     orig_q;
    verdict_t vd;

    assign vd = judge(tgt, arr, vld, dly_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_o   <= '0;
            orig_q  <= '0;
            tuned_o <= 1'b0;
        end else if (start) begin
            orig_q  <= dly_o;
            tuned_o <= 1'b0;
        end else if (stop) begin
            if (!tuned_o)
                dly_o <= orig_q;
        end else if (cfg_en) begin
            dly_o   <= cfg_dly;
            tuned_o <= 1'b0;
        end else if (eval && vd.ok) begin
            dly_o   <= vd.next;
            tuned_o <= vd.reach;
        end
    end

    AST_UNREACH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (eval && vd.ok && !vd.reach) |=> ($stable(dly_o) && !tuned_o)); // R5
    AST_SKIP_INVALID: assert property (@(posedge clk) disable iff (rst)
        (eval && !vd.ok) |=> ($stable(dly_o) && $stable(tuned_o))); // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> !tuned_o); // R7
    AST_STOP_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (stop && !tuned_o) |=> (dly_o == $past(orig_q))); // R8
endmodule

// File: rtl/dly_tune_top.sv
module dly_tune_top
    import dly_tune_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int ORBIT_DIV = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run_en,
    input  logic                   step_mode,
    input  logic                   step,
    input  logic                   nth_en,
    input  logic                   orbit_tick,
    input  logic [BCN_W-1:0]       target,
    input  logic [NCH*BCN_W-1:0]   cap_bcn,
    input  logic [NCH-1:0]         cap_valid,
    input  logic                   cfg_load,
    input  logic [NCH*DLY_W-1:0]   cfg_dly,
    output logic [NCH*DLY_W-1:0]   dly,
    output logic [NCH-1:0]         tuned
);
    logic eval, start, stop, idle, cfg_en;

    dly_orbit_pacer #(.ORBIT_DIV(ORBIT_DIV)) u_pacer (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .step_mode  (step_mode),
        .step       (step),
        .nth_en     (nth_en),
        .orbit_tick (orbit_tick),
        .eval       (eval),
        .start      (start),
        .stop       (stop),
        .idle       (idle)
    );

    assign cfg_en = cfg_load && idle;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dly_chan_tuner u_ch (
            .clk     (clk),
            .rst     (rst),
            .start   (start),
            .stop    (stop),
            .eval    (eval),
            .cfg_en  (cfg_en),
            .tgt     (target),
            .arr     (cap_bcn[c*BCN_W +: BCN_W]),
            .vld     (cap_valid[c]),
            .cfg_dly (cfg_dly[c*DLY_W +: DLY_W]),
            .dly_o   (dly[c*DLY_W +: DLY_W]),
            .tuned_o (tuned[c])
        );
    end

    AST_CFG_IGNORED_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        (run_en && !start && cfg_load && !eval) |=> ($stable(dly) && $stable(tuned))); // R2
endmodule

// File: tb/tb_dly_tune_top.sv
module tb_dly_tune_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH       = 4;
    localparam int DIV       = 4;
    localparam int L         = 3563;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 0, step_mode = 0, step = 0, nth_en = 0, orbit_tick = 0, cfg_load = 0;
    logic [11:0] target = 12'd1;
    logic [NCH*12-1:0] cap_bcn = '0;
    logic [NCH-1:0] cap_valid = '0;
    logic [NCH*2-1:0] cfg_dly = '0;
    logic [NCH*2-1:0] dly;
    logic [NCH-1:0] tuned;

    int errors = 0, checks = 0;
    int m_dly [NCH];
    int m_orig[NCH];
    bit m_tuned[NCH];
    bit m_runq;
    int m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dly_tune_top #(.NCH(NCH), .ORBIT_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .run_en(run_en), .step_mode(step_mode), .step(step),
        .nth_en(nth_en), .orbit_tick(orbit_tick), .target(target), .cap_bcn(cap_bcn),
        .cap_valid(cap_valid), .cfg_load(cfg_load), .cfg_dly(cfg_dly), .dly(dly), .tuned(tuned)
    );

    function automatic bit in_orbit(int b);
        return (b >= 1) && (b <= L);
    endfunction

    function automatic int fold(int t, int a);
        int d = t - a;
        if (d > L/2) d -= L;
        else if (d < -(L/2)) d += L;
        return d;
    endfunction

    function automatic int wrap(int b);
        int x = b;
        while (x < 1) x += L;
        while (x > L) x -= L;
        return x;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        for (int c = 0; c < NCH; c++) begin
            check(tag, int'(dly[c*2 +: 2]), m_dly[c], $sformatf("dly[%0d]", c));
            check(tag, int'(tuned[c]), int'(m_tuned[c]), $sformatf("tuned[%0d]", c));
        end
    endtask

    task automatic tick(string tag);
        bit ev, st, sp, idle;
        int n_dly[NCH];
        bit n_tuned[NCH];
        int n_orig[NCH];
        st = run_en && !m_runq;
        sp = !run_en && m_runq;
        idle = !run_en && !m_runq;
        ev = 0;
        if (run_en && m_runq)
            ev = step_mode ? step : (nth_en ? (orbit_tick && m_cnt == DIV-1) : 1'b1);
        for (int c = 0; c < NCH; c++) begin
            int a = int'(cap_bcn[c*12 +: 12]);
            n_dly[c] = m_dly[c]; n_tuned[c] = m_tuned[c]; n_orig[c] = m_orig[c];
            if (st) begin
                n_orig[c] = m_dly[c]; n_tuned[c] = 0;
            end else if (sp) begin
                if (!m_tuned[c]) n_dly[c] = m_orig[c];
            end else if (cfg_load && idle) begin
                n_dly[c] = int'(cfg_dly[c*2 +: 2]); n_tuned[c] = 0;
            end else if (ev && cap_valid[c] && in_orbit(a) && in_orbit(int'(target))) begin
                int nd = m_dly[c] + fold(int'(target), a);
                if (nd >= 0 && nd <= 3) begin n_dly[c] = nd; n_tuned[c] = 1; end
                else n_tuned[c] = 0;
            end
        end
        if (!run_en) m_cnt = 0;
        else if (orbit_tick && nth_en && !step_mode) m_cnt = (m_cnt == DIV-1) ? 0 : m_cnt + 1;
        m_runq = run_en;
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            m_dly[c] = n_dly[c]; m_tuned[c] = n_tuned[c]; m_orig[c] = n_orig[c];
        end
        compare_all(tag);
    endtask

    task automatic set_cap(int c, int b, bit v);
        cap_bcn[c*12 +: 12] = 12'(b);
        cap_valid[c] = v;
    endtask

    task automatic load_cfg(int d0, int d1, int d2, int d3);
        cfg_dly = {2'(d3), 2'(d2), 2'(d1), 2'(d0)};
        cfg_load = 1; tick("R2 cfg load idle"); cfg_load = 0;
    endtask

    task automatic one_step(string tag);
        step = 1; tick(tag); step = 0; tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) begin m_dly[c] = 0; m_orig[c] = 0; m_tuned[c] = 0; end
        m_runq = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        compare_all("R1 reset state");

        // R3 R4 R5 R6 : step mode, target 8
        load_cfg(0, 0, 3, 1);
        target = 12'd8; step_mode = 1;
        set_cap(0, 6, 1); set_cap(1, 4, 1); set_cap(2, 10, 1); set_cap(3, 12'hDEF, 1);
        run_en = 1; tick("R7 start");
        tick("R11 no step no eval");
        one_step("R4 R5 R6 step eval target 8");
        // R2: cfg load during session ignored
        cfg_dly = '1; cfg_load = 1; tick("R2 cfg ignored in run"); cfg_load = 0;
        run_en = 0; tick("R8 stop keeps tuned");
        tick("R8 after stop");

        // R3 wrap: target 3563
        load_cfg(3, 1, 0, 2);
        target = 12'd3563;
        set_cap(0, 1, 1); set_cap(1, 3563, 1); set_cap(2, 1, 1); set_cap(3, 3562, 0);
        run_en = 1; tick("R7 start");
        one_step("R3 orbit wrap");
        run_en = 0; tick("R8 stop restore");

        // R8 restore after a move then overshoot
        load_cfg(0, 0, 0, 0);
        target = 12'd8;
        for (int c = 0; c < NCH; c++) set_cap(c, 6, 1);
        run_en = 1; tick("R7 start");
        one_step("R4 first move");
        one_step("R5 overshoot");
        run_en = 0; tick("R8 restore original");

        // R6 invalid target and zero capture
        target = 12'd0; set_cap(0, 0, 1);
        run_en = 1; tick("R7 start");
        one_step("R6 invalid target");
        run_en = 0; tick("R8 stop");

        // R10 orbit mode
        target = 12'd9; step_mode = 0; nth_en = 1;
        for (int c = 0; c < NCH; c++) set_cap(c, 8, 1);
        run_en = 1; tick("R7 start");
        for (int k = 0; k < 2*DIV; k++) begin
            orbit_tick = 1; tick("R10 orbit tick"); orbit_tick = 0;
            tick("R10 between ticks");
        end
        run_en = 0; tick("R8 stop");

        // R9 continuous with single-cycle valid
        nth_en = 0; target = 12'd2; cap_valid = '0;
        for (int c = 0; c < NCH; c++) set_cap(c, 3563, 0);
        run_en = 1; tick("R7 start");
        tick("R9 no valid");
        cap_valid = '1; tick("R9 continuous eval"); cap_valid = '0;
        tick("R9 hold");
        run_en = 0; tick("R8 stop");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(39) == 0) run_en = ~run_en;
            if ($urandom_range(49) == 0)
                target = ($urandom_range(2) == 0) ? 12'(wrap(1 + int'($urandom_range(4)) - 2))
                                                  : 12'($urandom_range(L, 1));
            step_mode = ($urandom_range(3) == 0);
            step = ($urandom_range(2) == 0);
            nth_en = ($urandom_range(2) == 0);
            orbit_tick = ($urandom_range(4) == 0);
            cfg_load = ($urandom_range(9) == 0);
            cfg_dly = NCH*2'($urandom);
            for (int c = 0; c < NCH; c++) begin
                int k = int'($urandom_range(8)) - 4;
                int b = wrap(int'(target) - k);
                int r = int'($urandom_range(11));
                if (r == 0) b = 'hDEF;
                else if (r == 1) b = 0;
                set_cap(c, b, $urandom_range(3) != 0);
            end
            tick("R3 R4 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule